// File: doc/BRIEF.md
# Two-Lane Selectable PRBS Test-Pattern Source

This block produces two independent serial test-pattern streams, one bit per clock on each lane. Each lane picks its pattern through a 2-bit select field. The choices are three maximal-length pseudo-random sequences (lengths 7, 15 and 23) and a square wave that toggles on every clock. Each sequence comes from a 23-bit Fibonacci shift register, of which only the low bits that the chosen length needs are active.

Software drives the block through a simple synchronous register port with address, write data, write enable and combinational read data. There is one select register per lane and one enable register that both lanes share. Stopping a lane takes two steps. Clearing a lane's enable bit leaves its stream running. The stream halts only when that lane's select register is written while the enable bit is clear. A halted lane drives 0 and freezes its shift register. Setting its enable bit again restarts the pattern from the all-ones seed.

Top module: `twin_prbs_source`

## Requirements
- R1: After reset both lane outputs are 0, both select fields read 0 and the enable register reads 0.
- R2: Select code 2'b00 gives the length-7 sequence x^7+x^6+1: new bit = s[6]^s[5], shifted in at bit 0, output s[6]. One period holds 127 bits, of which 64 are ones.
- R3: Select code 2'b01 gives the length-15 sequence x^15+x^14+1: new bit = s[14]^s[13], output s[14]. One period of 32767 bits holds 16384 ones.
- R4: Select code 2'b10 gives the length-23 sequence x^23+x^18+1: new bit = s[22]^s[17], output s[22].
- R5: Select code 2'b11 gives a square wave. Its first bit after a reload is 1, and it inverts on every later clock while the lane runs.
- R6: Every write to a lane's select register reloads that lane with the all-ones seed. The first output bit after the write edge is the seed's top active bit, which is 1. A running lane then steps once per clock.
- R7: Clearing a lane's enable bit (enable register bit i) does not stop the lane. It keeps stepping and driving its pattern.
- R8: A write to a lane's select register while that lane's enable bit is 0 stops the lane. A stopped lane outputs 0 and its sequence does not advance.
- R9: Writing enable bit i from 0 to 1 restarts lane i from the seed in the selected pattern. Writing 1 to a bit that is already 1 has no effect.
- R10: The select register of lane i is at BASE+i (default 0x800 and 0x801), reading the code in bits [1:0]. The enable register is at BASE+2 (0x802), with bit i for lane i. Unused bits and unmapped addresses read 0.
- R11: Lanes are independent: writes aimed at one lane never change the other lane's stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | ADDR_W (12) | Register address |
| cfg_wdata | input | DATA_W (8) | Register write data |
| cfg_we | input | 1 | Write strobe, one write per clock |
| cfg_rdata | output | DATA_W (8) | Read data for cfg_addr, combinational |
| pat_out | output | NUM_LANES (2) | Serial pattern bit, one per lane |

## Verification
The state that is hardest to reach from the ports is a lane whose enable is clear but which is still running. It is invisible in the register readback and shows only in the stream. The stimulus gets there by starting both lanes, writing 0 to the enable register, and following both streams bit for bit. It then writes one lane's select register to stop that lane alone, and sets enable again to restart the lane from its seed while the other lane keeps its phase. A cycle-accurate model in the bench follows every write. It also counts the ones over a full 127-bit period and a full 32767-bit period.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

   localparam int unsigned MAX_LEN = 23;
   localparam int unsigned NUM_PRBS = 3;

   typedef enum logic [1:0] {
      PAT_P7  = 2'b00,
      PAT_P15 = 2'b01,
      PAT_P23 = 2'b10,
      PAT_SQ  = 2'b11
   } pat_e;

   // register length for a pseudo-random code
   function automatic int unsigned pat_len(input int unsigned code);
      case (code)
         0:       return 7;
         1:       return 15;
         default: return 23;
      endcase
   endfunction

   // exponent of the inner feedback term
   function automatic int unsigned pat_tap(input int unsigned code);
      case (code)
         0:       return 6;
         1:       return 14;
         default: return 18;
      endcase
   endfunction

endpackage

// File: rtl/pgen_lfsr.sv
module pgen_lfsr
   import pgen_pkg::*;
#(
   parameter int unsigned W = MAX_LEN
) (
   input  logic         clk,
   input  logic         rst_n,
   input  pat_e         mode,
   input  logic         load,
   input  logic         adv,
   output logic [W-1:0] state_q,
   output logic         top_bit
);

   if (W < MAX_LEN) begin : g_chk_w
      $error("pgen_lfsr: W must cover the longest sequence");
   end

   logic [NUM_PRBS-1:0] fb_v;
   logic [NUM_PRBS-1:0] top_v;
   logic [W-1:0]        mask_v [NUM_PRBS];

   for (genvar m = 0; m < NUM_PRBS; m++) begin : g_poly
      localparam int unsigned LEN = pat_len(m);
      localparam int unsigned TAP = pat_tap(m);
      if (TAP >= LEN || LEN > W) begin : g_chk_tap
         $error("pgen_lfsr: bad polynomial table");
      end
      assign fb_v[m]   = state_q[LEN-1] ^ state_q[TAP-1];
      assign top_v[m]  = state_q[LEN-1];
      assign mask_v[m] = W'((64'd1 << LEN) - 64'd1);
   end

   logic         fb;
   logic [W-1:0] mask;
   logic [W-1:0] state_d;

   always_comb begin
      fb      = 1'b0;
      top_bit = 1'b0;
      mask    = '0;
      for (int m = 0; m < NUM_PRBS; m++) begin
         if (int'(mode) == m) begin
            fb      = fb_v[m];
            top_bit = top_v[m];
            mask    = mask_v[m];
         end
      end
   end

   always_comb begin
      if (load)
         state_d = '1;
      else if (adv)
         state_d = {state_q[W-2:0], fb} & mask;
      else
         state_d = state_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= '1;
      else
         state_q <= state_d;
   end

   // R6: a load always leaves the seed behind
   a_r6_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (state_q == '1));

   // R2: the active window never collapses to zero
   a_r2_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != PAT_SQ) |-> ((state_q & mask) != '0));

endmodule

// File: rtl/pgen_regs.sv
module pgen_regs
   import pgen_pkg::*;
#(
   parameter int unsigned NUM_LANES = 2,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned BASE_ADDR = 'h800
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 we,
   output logic [DATA_W-1:0]    rdata,
   output pat_e                 sel_q   [NUM_LANES],
   output logic [NUM_LANES-1:0] en_q,
   output logic [NUM_LANES-1:0] sel_wr,
   output logic [NUM_LANES-1:0] en_set
);

   localparam int unsigned EN_ADDR = BASE_ADDR + NUM_LANES;

   if (DATA_W < NUM_LANES || DATA_W < 2) begin : g_chk_data
      $error("pgen_regs: DATA_W too narrow");
   end
   if (EN_ADDR >= (64'd1 << ADDR_W)) begin : g_chk_addr
      $error("pgen_regs: register window outside address space");
   end

   logic en_hit;
   logic [NUM_LANES-1:0] sel_hit;

   assign en_hit = (addr == ADDR_W'(EN_ADDR));

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_sel
      assign sel_hit[i] = (addr == ADDR_W'(BASE_ADDR + i));
      assign sel_wr[i]  = we & sel_hit[i];
      assign en_set[i]  = we & en_hit & wdata[i] & ~en_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sel_q[i] <= PAT_P7;
         else if (sel_wr[i])
            sel_q[i] <= pat_e'(wdata[1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (we & en_hit)
         en_q <= wdata[NUM_LANES-1:0];
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_LANES; i++) begin
         if (sel_hit[i])
            rdata[1:0] = sel_q[i];
      end
      if (en_hit)
         rdata[NUM_LANES-1:0] = en_q;
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   // R10: addresses outside the window read zero
   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_hit && sel_hit == '0) |-> (rdata == '0));

   // R10: the enable register keeps its value without a write to it
   a_r10_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && en_hit) |=> $stable(en_q));

endmodule

// File: rtl/pgen_lane.sv
module pgen_lane
   import pgen_pkg::*;
#(
   parameter int unsigned LFSR_W = MAX_LEN
) (
   input  logic clk,
   input  logic rst_n,
   input  pat_e mode,
   input  logic en,
   input  logic sel_wr,
   input  logic en_set,
   output logic bit_o
);

   logic              run_q;
   logic              sq_q;
   logic              reload;
   logic              adv;
   logic              lfsr_top;
   logic [LFSR_W-1:0] lfsr_state;

   assign reload = sel_wr | en_set;
   assign adv    = run_q & ~reload;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         sq_q  <= 1'b1;
      end else begin
         if (en_set)
            run_q <= 1'b1;
         else if (sel_wr && !en)
            run_q <= 1'b0;

         if (reload)
            sq_q <= 1'b1;
         else if (adv)
            sq_q <= ~sq_q;
      end
   end

   pgen_lfsr #(.W(LFSR_W)) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .load    (reload),
      .adv     (adv && (mode != PAT_SQ)),
      .state_q (lfsr_state),
      .top_bit (lfsr_top)
   );

   assign bit_o = run_q & ((mode == PAT_SQ) ? sq_q : lfsr_top);

   // R7: only a select write or a restart can change a running lane
   a_r7_keep_running: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !sel_wr && !en_set) |=> run_q);

   // R8: select write while disabled halts the lane and silences it
   a_r8_stop_on_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr && !en) |=> (!run_q && !bit_o));

   // R8: a halted lane keeps its register frozen and drives 0
   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !reload) |=> ($stable(lfsr_state) && !bit_o));

   // R9: rising enable restarts the lane
   a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      en_set |=> run_q);

   // R5: square phase flips each running clock
   a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !reload) |=> (sq_q != $past(sq_q)));

endmodule

// File: rtl/twin_prbs_source.sv
module twin_prbs_source
   import pgen_pkg::*;
#(
   parameter int unsigned NUM_LANES = 2,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned BASE_ADDR = 'h800
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    cfg_addr,
   input  logic [DATA_W-1:0]    cfg_wdata,
   input  logic                 cfg_we,
   output logic [DATA_W-1:0]    cfg_rdata,
   output logic [NUM_LANES-1:0] pat_out
);

   if (NUM_LANES < 1) begin : g_chk_lanes
      $error("twin_prbs_source: need at least one lane");
   end

   pat_e                 sel_q [NUM_LANES];
   logic [NUM_LANES-1:0] en_q;
   logic [NUM_LANES-1:0] sel_wr;
   logic [NUM_LANES-1:0] en_set;

   pgen_regs #(
      .NUM_LANES (NUM_LANES),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (cfg_addr),
      .wdata  (cfg_wdata),
      .we     (cfg_we),
      .rdata  (cfg_rdata),
      .sel_q  (sel_q),
      .en_q   (en_q),
      .sel_wr (sel_wr),
      .en_set (en_set)
   );

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      pgen_lane #(.LFSR_W(MAX_LEN)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .mode   (sel_q[i]),
         .en     (en_q[i]),
         .sel_wr (sel_wr[i]),
         .en_set (en_set[i]),
         .bit_o  (pat_out[i])
      );
   end

   // R11: one register access targets at most one lane's select
   a_r11_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_wr));

endmodule

// File: tb/tb_twin_prbs_source.sv
module tb_twin_prbs_source;

   localparam int unsigned NL   = 2;
   localparam logic [11:0] A_S0 = 12'h800;
   localparam logic [11:0] A_S1 = 12'h801;
   localparam logic [11:0] A_EN = 12'h802;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_rdata;
   logic [1:0]  pat_out;

   twin_prbs_source dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_we    (cfg_we),
      .cfg_rdata (cfg_rdata),
      .pat_out   (pat_out)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   string tag = "R1";

   // bench model of each lane, built from the requirements
   logic [22:0] m_st  [NL];
   logic        m_run [NL];
   logic        m_sq  [NL];
   logic        m_en  [NL];
   logic [1:0]  m_sel [NL];
   int          ones  [NL];

   function automatic int mlen(input logic [1:0] s);
      return (s == 2'd0) ? 7 : (s == 2'd1) ? 15 : 23;
   endfunction
   function automatic int mtap(input logic [1:0] s);
      return (s == 2'd0) ? 6 : (s == 2'd1) ? 14 : 18;
   endfunction

   function automatic logic m_out(input int l);
      if (!m_run[l]) return 1'b0;
      if (m_sel[l] == 2'd3) return m_sq[l];
      return m_st[l][mlen(m_sel[l]) - 1];
   endfunction

   task automatic check(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic model_edge(input logic we, input logic [11:0] a, input logic [7:0] d);
      for (int l = 0; l < NL; l++) begin
         bit sw, es;
         sw = we && (a == A_S0 + 12'(l));
         es = we && (a == A_EN) && d[l] && !m_en[l];
         if (sw || es) begin
            if (sw) m_sel[l] = d[1:0];
            m_st[l] = '1;
            m_sq[l] = 1'b1;
            if (es) m_run[l] = 1'b1;
            else if (!m_en[l]) m_run[l] = 1'b0;
         end else if (m_run[l]) begin
            int n, t;
            n = mlen(m_sel[l]);
            t = mtap(m_sel[l]);
            if (m_sel[l] != 2'd3)
               m_st[l] = ({m_st[l][21:0], m_st[l][n-1] ^ m_st[l][t-1]}) & 23'((64'd1 << n) - 1);
            m_sq[l] = ~m_sq[l];
         end
      end
      if (we && a == A_EN)
         for (int l = 0; l < NL; l++) m_en[l] = d[l];
   endtask

   // compare both lanes, then present the next access
   task automatic cyc(input logic we, input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      for (int l = 0; l < NL; l++) begin
         check(pat_out[l] === m_out(l), $sformatf("lane%0d stream", l), pat_out[l], m_out(l));
         ones[l] += int'(pat_out[l]);
      end
      cfg_we = we;
      cfg_addr = a;
      cfg_wdata = d;
      model_edge(we, a, d);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 12'h000, 8'h00);
   endtask

   task automatic rd(input logic [11:0] a, input logic [7:0] exp);
      cyc(1'b0, a, 8'h00);
      #1;
      check(cfg_rdata === exp, $sformatf("read 0x%03h", a), cfg_rdata, exp);
   endtask

   task automatic clear_ones();
      for (int l = 0; l < NL; l++) ones[l] = 0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      for (int l = 0; l < NL; l++) begin
         m_st[l] = '1; m_run[l] = 0; m_sq[l] = 1; m_en[l] = 0; m_sel[l] = 0; ones[l] = 0;
      end
      repeat (3) @(negedge clk);
      tag = "R1";
      check(pat_out === 2'b00, "outputs in reset", pat_out, 0);
      rst_n = 1'b1;
      run(4);
      rd(A_S0, 8'h00);
      rd(A_S1, 8'h00);
      rd(A_EN, 8'h00);

      // R10 field placement, unused bits, unmapped reads
      tag = "R10";
      cyc(1'b1, A_S0, 8'hFD);
      cyc(1'b1, A_S1, 8'hFF);
      rd(A_S0, 8'h01);
      rd(A_S1, 8'h03);
      rd(12'h803, 8'h00);
      rd(12'h000, 8'h00);
      rd(12'hFFF, 8'h00);
      rd(12'h7FF, 8'h00);
      tag = "R8";
      run(10);

      // R2 and R5: start both lanes together
      tag = "R2";
      cyc(1'b1, A_S0, 8'h00);
      cyc(1'b1, A_EN, 8'h03);
      clear_ones();
      run(127);
      check(ones[0] == 64, "R2 ones in one 7-bit period", ones[0], 64);
      tag = "R5";
      check(ones[1] == 64, "R5 square ones in 127 bits", ones[1], 64);
      run(200);
      rd(A_EN, 8'h03);

      // R3 and R6: reload into the 15-bit sequence while running
      tag = "R6";
      cyc(1'b1, A_S0, 8'h01);
      clear_ones();
      cyc(1'b0, 12'h000, 8'h00);
      check(ones[0] == 1, "R6 first bit after reload", ones[0], 1);
      tag = "R3";
      run(32766);
      check(ones[0] == 16384, "R3 ones in one 15-bit period", ones[0], 16384);

      // R4: lane 1 to the 23-bit sequence
      tag = "R4";
      cyc(1'b1, A_S1, 8'h02);
      run(3000);
      rd(A_S1, 8'h02);

      // R7: clear both enables, streams continue
      tag = "R7";
      cyc(1'b1, A_EN, 8'h00);
      clear_ones();
      run(500);
      check(ones[0] > 0 && ones[1] > 0, "R7 lanes still active", ones[0] + ones[1], 1);
      rd(A_EN, 8'h00);

      // R8 and R11: stop lane 0 only
      tag = "R8";
      cyc(1'b1, A_S0, 8'h00);
      clear_ones();
      run(200);
      check(ones[0] == 0, "R8 stopped lane silent", ones[0], 0);
      tag = "R11";
      check(ones[1] > 0, "R11 lane1 unaffected", ones[1], 1);

      // R9: restart lane 0 from the seed in 7-bit mode
      tag = "R9";
      cyc(1'b1, A_EN, 8'h01);
      clear_ones();
      run(127);
      check(ones[0] == 64, "R9 restart full period", ones[0], 64);

      // R8 and R9 on lane 1: stop, then restart as square wave
      tag = "R8";
      cyc(1'b1, A_S1, 8'h03);
      run(50);
      tag = "R9";
      cyc(1'b1, A_EN, 8'h03);
      run(60);
      cyc(1'b1, A_EN, 8'h03);
      run(60);
      tag = "R11";
      cyc(1'b1, A_S1, 8'h03);
      run(100);

      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

endmodule